// File: doc/BRIEF.md
# Parallel Carry-Less CRC-32 Folding Engine

This block takes a message of at least 64 bytes and reduces it to a 128-bit partial remainder for the CRC-32 generator x^32 + x^26 + x^23 + x^22 + x^16 + x^12 + x^11 + x^10 + x^8 + x^7 + x^5 + x^4 + x^2 + x + 1 (0x104C11DB7). Message bits are taken most significant first, with no bit reflection. The message arrives as wide beats over a valid/ready stream. Each beat holds `LANES` 128-bit chunks, four by default. Each chunk feeds one fold lane. Every lane uses two 64x64 carry-less multiplies and XORs the products with the matching chunk of the next beat. The multiplier constants are x^(128·LANES+64) mod P and x^(128·LANES) mod P.

The last beat may be full, or it may be short and carry one to `LANES-1` trailing chunks. Once it is accepted, a single narrow fold step takes over, using x^192 mod P and x^128 mod P. That step first folds lanes 1, 2, 3 in turn into lane 0, then folds in each trailing chunk. The final 128-bit value is given on `rem_out` together with a one-cycle `rem_done` strobe. A later stage reduces it to 32 bits: the CRC equals (rem_out · x^32) mod P. Bit reflection, tails shorter than 16 bytes and the final 32-bit reduction are all outside this block.

Top module: `crcf_fold_engine`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `rem_done` is 0 and `rem_out` is 0.
- R2: Take the reported `rem_out` and shift it MSB-first into a 32-bit CRC register that starts at zero, using polynomial 0x04C11DB7. The result equals the MSB-first CRC of the message with `crc_init` as the starting value, no reflection and no final inversion.
- R3: The chunk at `in_data[511:384]` is earliest in the message, and bit 511 is its first bit. `crc_init` is XORed onto bits [511:480] of the first beat. A message with init I therefore gives exactly the same `rem_out` as the same message with init 0 and I XORed into those bits.
- R4: The first beat always counts as `LANES` chunks. On a later last beat, `in_chunks` from 1 to `LANES-1` means that only that many chunks, counted from the top, belong to the message. Any other value (0, or `LANES` and above) means a full beat.
- R5: `in_ready` is 1 while the engine waits for or streams a message. It is 0 from the edge that accepts the last beat up to and including the `rem_done` cycle. A beat offered while `in_ready` is 0 is ignored.
- R6: `rem_done` goes high on the (LANES-1+k)-th rising edge after the edge that accepts the last beat, where k is the number of trailing chunks. It stays high for exactly one cycle, and `in_ready` returns on the next edge.
- R7: `rem_out` holds its value from the `rem_done` cycle until the last beat of the next message is accepted.
- R8: `crc_init` is sampled only together with the first beat. Its value during later beats has no effect.
- R9: Cycles with `in_valid` low between beats of a message do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Engine can accept a beat |
| in_data | input | 128·LANES (512) | Beat payload, earliest chunk in the top 128 bits |
| in_chunks | input | CNT_W (3) | Chunk count of a short last beat |
| in_last | input | 1 | Beat is the final one of the message |
| crc_init | input | 32 | Initial CRC value, used with the first beat |
| rem_out | output | 128 | Folded 128-bit partial remainder |
| rem_done | output | 1 | One-cycle strobe: `rem_out` is valid |

## Verification
The sweep runs every combination of one to four full beats with zero to three trailing chunks. Each combination is tried with all-zero data, all-ones data, a single set bit and pseudo-random data, and with initial values of zero and all ones. Zero data with init zero shows whether anything leaks into the lanes other than the message. All-ones and single-bit data expose a wrong constant or a wrong lane or chunk order. Random data with a nonzero init checks the overall congruence with a bit-serial CRC.

Unused chunk slots, the first-beat `in_chunks` value, out-of-range counts, beats offered while the engine is busy, mid-message `crc_init` noise and idle gaps are all filled with garbage. Any of these leaking into the result changes the CRC comparison. A paired run compares `rem_out` exactly to show where the initial value lands.

// File: rtl/crcf_pkg.sv
package crcf_pkg;

    localparam int CHUNK_W = 128;
    localparam int HALF_W  = 64;
    localparam int CRC_W   = 32;

    // Generator without its x^32 term
    localparam logic [CRC_W-1:0] GEN_LOW = 32'h04C11DB7;

    typedef logic [CHUNK_W-1:0] chunk_t;
    typedef logic [HALF_W-1:0]  half_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WIDE  = 2'd1,
        ST_MERGE = 2'd2,
        ST_DONE  = 2'd3
    } fold_state_e;

    // x^n mod P, evaluated at elaboration for the fold constants
    function automatic logic [CRC_W-1:0] xpow_mod(input int n);
        logic [CRC_W-1:0] r;
        logic             msb;
        r = 32'h1;
        for (int i = 0; i < n; i++) begin
            msb = r[CRC_W-1];
            r   = {r[CRC_W-2:0], 1'b0};
            if (msb) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

    function automatic half_t fold_const(input int n);
        return {{(HALF_W-CRC_W){1'b0}}, xpow_mod(n)};
    endfunction

endpackage

// File: rtl/crcf_clmul64.sv
module crcf_clmul64
    import crcf_pkg::*;
(
    input  half_t  a,
    input  half_t  b,
    output chunk_t p
);
    // Carry-less product, degree <= 126, zero-extended to 128 bits
    always_comb begin
        p = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if (b[i]) p = p ^ (chunk_t'(a) << i);
        end
    end
endmodule

// File: rtl/crcf_fold_step.sv
module crcf_fold_step
    import crcf_pkg::*;
#(
    parameter half_t K_HI = '0,
    parameter half_t K_LO = '0
) (
    input  chunk_t acc,
    input  chunk_t nxt,
    output chunk_t res
);
    chunk_t prod_hi;
    chunk_t prod_lo;

    crcf_clmul64 u_mul_hi (.a(acc[CHUNK_W-1:HALF_W]), .b(K_HI), .p(prod_hi));
    crcf_clmul64 u_mul_lo (.a(acc[HALF_W-1:0]),       .b(K_LO), .p(prod_lo));

    assign res = prod_hi ^ prod_lo ^ nxt;
endmodule

// File: rtl/crcf_fold_engine.sv
module crcf_fold_engine
    import crcf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [LANES*CHUNK_W-1:0]   in_data,
    input  logic [CNT_W-1:0]           in_chunks,
    input  logic                       in_last,
    input  logic [CRC_W-1:0]           crc_init,
    output logic [CHUNK_W-1:0]         rem_out,
    output logic                       rem_done
);
    localparam int    BEAT_W = LANES * CHUNK_W;
    localparam int    QDEPTH = 2 * (LANES - 1);
    localparam int    STEP_W = $clog2(QDEPTH + 1);
    localparam half_t KW_HI  = fold_const(BEAT_W + HALF_W);
    localparam half_t KW_LO  = fold_const(BEAT_W);
    localparam half_t KN_HI  = fold_const(CHUNK_W + HALF_W);
    localparam half_t KN_LO  = fold_const(CHUNK_W);

    fold_state_e       state_q;
    chunk_t            lane_q    [LANES];
    chunk_t            lane_fold [LANES];
    chunk_t            lane_new  [LANES];
    chunk_t            in_chunk  [LANES];
    chunk_t            q_q       [QDEPTH];
    chunk_t            q_load    [QDEPTH];
    chunk_t            q_shift   [QDEPTH];
    chunk_t            acc_q;
    chunk_t            merge_res;
    logic [STEP_W-1:0] steps_q;
    logic              accept;
    logic              first_beat;
    logic              short_last;
    logic [CNT_W-1:0]  tail_cnt;

    assign in_ready   = (state_q == ST_IDLE) || (state_q == ST_WIDE);
    assign accept     = in_valid && in_ready;
    assign first_beat = (state_q == ST_IDLE);
    assign short_last = in_last && !first_beat && (in_chunks != '0)
                        && (in_chunks < CNT_W'(LANES));
    assign tail_cnt   = short_last ? in_chunks : '0;

    // Wide lanes: one fold unit per lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign in_chunk[i] = in_data[BEAT_W-1-i*CHUNK_W -: CHUNK_W];

        crcf_fold_step #(.K_HI(KW_HI), .K_LO(KW_LO)) u_wide (
            .acc(lane_q[i]), .nxt(in_chunk[i]), .res(lane_fold[i])
        );

        if (i == 0) begin : g_seed
            assign lane_new[i] = first_beat
                ? (in_chunk[i] ^ {crc_init, {(CHUNK_W-CRC_W){1'b0}}})
                : (short_last ? lane_q[i] : lane_fold[i]);
        end else begin : g_plain
            assign lane_new[i] = first_beat ? in_chunk[i]
                : (short_last ? lane_q[i] : lane_fold[i]);
        end
    end

    // Merge queue: remaining lanes first, then trailing chunks
    for (genvar j = 0; j < QDEPTH; j++) begin : g_queue
        if (j < LANES - 1) begin : g_from_lane
            assign q_load[j] = lane_new[j+1];
        end else begin : g_from_tail
            assign q_load[j] = in_chunk[j-(LANES-1)];
        end
        if (j == QDEPTH - 1) begin : g_end
            assign q_shift[j] = '0;
        end else begin : g_mid
            assign q_shift[j] = q_q[j+1];
        end
    end

    // Single narrow fold step shared by merge and tail folding
    crcf_fold_step #(.K_HI(KN_HI), .K_LO(KN_LO)) u_narrow (
        .acc(acc_q), .nxt(q_q[0]), .res(merge_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            steps_q <= '0;
            for (int i = 0; i < LANES; i++)  lane_q[i] <= '0;
            for (int j = 0; j < QDEPTH; j++) q_q[j]    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WIDE: begin
                    if (accept) begin
                        for (int i = 0; i < LANES; i++) lane_q[i] <= lane_new[i];
                        if (in_last) begin
                            acc_q   <= lane_new[0];
                            for (int j = 0; j < QDEPTH; j++) q_q[j] <= q_load[j];
                            steps_q <= STEP_W'(LANES - 1) + STEP_W'(tail_cnt);
                            state_q <= ST_MERGE;
                        end else begin
                            state_q <= ST_WIDE;
                        end
                    end
                end
                ST_MERGE: begin
                    acc_q   <= merge_res;
                    for (int j = 0; j < QDEPTH; j++) q_q[j] <= q_shift[j];
                    steps_q <= steps_q - 1'b1;
                    if (steps_q == STEP_W'(1)) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rem_out  = acc_q;
    assign rem_done = (state_q == ST_DONE);
endmodule

// File: rtl/crcf_fold_engine_chk.sv
module crcf_fold_engine_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         in_last,
    input logic [127:0] rem_out,
    input logic         rem_done
);
    // R1: first cycle out of reset is idle and ready
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !rem_done));

    // R5: accepting the last beat closes the input
    p_last_closes_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R5: no beat is taken while the result is presented
    p_busy_at_done_r5: assert property (@(posedge clk) disable iff (rst)
        rem_done |-> !in_ready);

    // R6: strobe lasts one cycle, input reopens right after
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rem_done |=> (!rem_done && in_ready));

    // R7: result holds after the strobe
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        rem_done |=> $stable(rem_out));
endmodule

bind crcf_fold_engine crcf_fold_engine_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .rem_out(rem_out), .rem_done(rem_done)
);

// File: tb/tb_crcf_fold_engine.sv
module tb_crcf_fold_engine;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int MAXCH      = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [511:0]   in_data = '0;
    logic [2:0]     in_chunks = '0;
    logic           in_last = 1'b0;
    logic [31:0]    crc_init = '0;
    logic [127:0]   rem_out;
    logic           rem_done;

    int n_tests = 0;
    int n_fail  = 0;

    logic [127:0] msg [MAXCH];
    int           nch;
    logic [63:0]  rs = 64'h9E3779B97F4A7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    crcf_fold_engine #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_chunks(in_chunks), .in_last(in_last),
        .crc_init(crc_init), .rem_out(rem_out), .rem_done(rem_done)
    );

    function automatic logic [63:0] rnd64();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    function automatic logic [127:0] rnd128();
        logic [63:0] hi;
        hi = rnd64();
        return {hi, rnd64()};
    endfunction

    function automatic logic [31:0] crc_feed(input logic [31:0] c, input logic [127:0] d);
        logic fb;
        for (int i = 127; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_msg(input int n, input int pat, input int seed);
        nch = n;
        for (int c = 0; c < MAXCH; c++) begin
            case (pat)
                0: msg[c] = '0;
                1: msg[c] = '1;
                2: msg[c] = (c == seed % n) ? (128'h1 << (seed % 128)) : '0;
                default: msg[c] = rnd128();
            endcase
        end
    endtask

    // Drives msg[0..nch-1]; returns rem_out and checks timing (R5, R6, R7)
    task automatic send(input logic [31:0] init, input bit gap, input bit noise,
                        input logic [2:0] full_code, output logic [127:0] res);
        int nfull;
        int k;
        int beats;
        int lat;
        logic [127:0] held;
        nfull = nch / LANES;
        k     = nch % LANES;
        beats = nfull + ((k > 0) ? 1 : 0);
        for (int b = 0; b < beats; b++) begin
            @(negedge clk);
            if (gap && b > 0) begin
                in_valid = 1'b0;
                in_data  = {rnd128(), rnd128(), rnd128(), rnd128()};
                crc_init = rnd64()[31:0];
                @(negedge clk);
            end
            for (int s = 0; s < LANES; s++) begin
                if (b * LANES + s < nch)
                    in_data[511 - s*128 -: 128] = msg[b*LANES + s];
                else
                    in_data[511 - s*128 -: 128] = rnd128();
            end
            in_valid = 1'b1;
            in_last  = (b == beats - 1);
            if (b == 0)                       in_chunks = 3'd2;
            else if (b == beats - 1 && k > 0) in_chunks = 3'(k);
            else                              in_chunks = full_code;
            crc_init = (b == 0 || !noise) ? init : rnd64()[31:0];
            check(in_ready === 1'b1, "R5 ready while streaming", {127'b0, in_ready}, 128'h1);
            @(posedge clk);
        end
        @(negedge clk);
        // R5: beats offered while busy must be ignored
        in_valid = 1'b1;
        in_last  = 1'b1;
        in_data  = {rnd128(), rnd128(), rnd128(), rnd128()};
        crc_init = rnd64()[31:0];
        lat = 0;
        while (!rem_done && lat < 40) begin
            check(in_ready === 1'b0, "R5 ready low while folding", {127'b0, in_ready}, 128'h0);
            lat++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(lat == LANES - 1 + k, "R6 latency to rem_done", 128'(lat), 128'(LANES - 1 + k));
        check(in_ready === 1'b0, "R5 ready low at rem_done", {127'b0, in_ready}, 128'h0);
        res  = rem_out;
        held = rem_out;
        @(negedge clk);
        check(rem_done === 1'b0, "R6 rem_done single cycle", {127'b0, rem_done}, 128'h0);
        check(in_ready === 1'b1, "R6 ready returns", {127'b0, in_ready}, 128'h1);
        check(rem_out === held, "R7 rem_out holds", rem_out, held);
    endtask

    function automatic logic [31:0] expected_crc(input logic [31:0] init);
        logic [31:0] c;
        c = init;
        for (int i = 0; i < nch; i++) c = crc_feed(c, msg[i]);
        return c;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] r;
        logic [127:0] r2;
        logic [31:0]  got;
        logic [31:0]  exp;
        logic [31:0]  init;
        logic [2:0]   code;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 reset in_ready", {127'b0, in_ready}, 128'h1);
        check(rem_done === 1'b0, "R1 reset rem_done", {127'b0, rem_done}, 128'h0);
        check(rem_out === '0, "R1 reset rem_out", rem_out, '0);

        // R2, R4, R8, R9: sweep of lengths, patterns and initial values
        for (int nf = 1; nf <= 4; nf++) begin
            for (int k = 0; k < LANES; k++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    for (int iv = 0; iv < 2; iv++) begin
                        init = iv ? 32'hFFFFFFFF : 32'h0;
                        fill_msg(nf * LANES + k, pat, nf * 37 + k * 11 + pat);
                        code = (pat == 1) ? 3'd0 : ((pat == 2) ? 3'd7 : 3'd4);
                        send(init, (pat + iv) % 2 == 1, pat >= 2, code, r);
                        got = crc_feed(32'h0, r);
                        exp = expected_crc(init);
                        check(got === exp, "R2 R4 R8 R9 remainder congruent to CRC",
                              {96'b0, got}, {96'b0, exp});
                    end
                end
            end
        end

        // R3: init lands on bits [511:480] of the first beat
        for (int t = 0; t < 4; t++) begin
            init = rnd64()[31:0];
            fill_msg(2 * LANES + t, 3, t);
            send(init, 1'b0, 1'b0, 3'd4, r);
            msg[0][127:96] = msg[0][127:96] ^ init;
            send(32'h0, 1'b1, 1'b0, 3'd4, r2);
            check(r === r2, "R3 init placement exact", r, r2);
        end

        // R7: result stays while idle
        r = rem_out;
        repeat (5) @(negedge clk);
        check(rem_out === r, "R7 rem_out stable in idle", rem_out, r);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule